// File: doc/BRIEF.md
# External Bus Write Cycle Controller

This block carries out single write accesses on an external memory bus of the asynchronous kind. A host presents an address and a data word on a request/acknowledge port. The controller then runs the access on the bus pins. It drives a chip-select, a write strobe and a read/not-write line, all active low. It also drives an address bus and a write-data bus that has a separate driver enable. The access passes through three programmed stages, counted in interface clock cycles. The setup stage comes first, then the strobe stage, then the hold stage.

The slow device can stretch the strobe stage through a ready input. In direct mode, the controller samples the raw ready pin at the end of the strobe stage. In synchronized mode, the pin first passes through a two-flop synchronizer. The sample that feeds the synchronizer is taken two cycles earlier, so the decision still falls on the same edge. Each sample that finds ready low adds one wait cycle, and the controller samples again on the next cycle. A configuration bit can switch ready off completely. Between accesses the address bus keeps the last address it drove.

Top module: `xbus_wr_ctrl`

## Requirements
- R1: While reset is asserted, the outputs take these values: chip-select, write strobe and read/not-write are high, the data driver enable and the acknowledge are low, and the address bus is zero.
- R2: A request is accepted only when no access is running. Chip-select and read/not-write go low in the first cycle after the accepting edge. They stay low for setup+strobe+hold+waits cycles, then return high together. Input changes while idle with no request leave chip-select high.
- R3: The write strobe is low from cycle index setup through cycle index setup+strobe+waits-1, counting from 0 at the first chip-select-low cycle. It is high in every other cycle, so it is always inside chip-select.
- R4: In direct ready mode (mode bit 0), the raw ready pin is sampled at the edge that ends cycle setup+strobe-1. Each sample that is low adds one wait cycle to the strobe stage, and sampling repeats on every cycle until ready is found high.
- R5: In synchronized ready mode (mode bit 1), the ready pin passes through two flops. The value the pin holds in cycle setup+strobe-3 decides the edge at the end of the strobe stage. Each later cycle in which the pin is still low adds one wait cycle.
- R6: When ready is disabled (enable bit 0), the ready pin is ignored and the strobe stage always lasts exactly its programmed count.
- R7: The acknowledge is high for exactly one cycle, the last hold-stage cycle, which is cycle setup+strobe+hold+waits-1.
- R8: The data driver enable rises one cycle after the write strobe falls. It stays high through the hold stage and falls one cycle after read/not-write returns high. While it is high, the data bus carries the word that was captured at acceptance.
- R9: The address is captured at acceptance. The bus holds it through the access and through all idle cycles until the next acceptance.
- R10: A programmed length of zero for any stage is treated as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host write request, held until acknowledged |
| req_addr | input | AW | Host write address |
| req_data | input | DW | Host write data |
| req_ack | output | 1 | One-cycle completion pulse |
| cfg_setup | input | CW | Setup stage length in cycles |
| cfg_strobe | input | CW | Strobe stage length in cycles |
| cfg_hold | input | CW | Hold stage length in cycles |
| cfg_rdy_en | input | 1 | 1 = ready pin extends the strobe stage |
| cfg_rdy_sync | input | 1 | 1 = synchronized ready mode, 0 = direct |
| xb_ready | input | 1 | Ready from the external device |
| xb_cs_n | output | 1 | Chip-select, active low |
| xb_we_n | output | 1 | Write strobe, active low |
| xb_rnw | output | 1 | Read/not-write, low during a write |
| xb_addr | output | AW | Address bus |
| xb_wdata | output | DW | Write data bus value |
| xb_wdata_oe | output | 1 | Write data driver enable |

## Verification
On every cycle, the assertions check the nesting of the strobes and the enables. They check that the write strobe lies inside chip-select and that the data driver enable never rises before the strobe has fallen. They also check that the driver enable falls only after read/not-write is high, that the address stays still while idle, that the acknowledge is a single pulse, and that the two-cycle synchronizer delay holds. The bench scenarios are the only way to confirm the actual stage lengths and the exact number of wait cycles for a given ready edge. The same holds for the difference between direct and synchronized sampling points, the treatment of zero lengths, and the captured data value.

// File: rtl/xbw_pkg.sv
`timescale 1ns/1ps
package xbw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } xbw_phase_e;

    // Flop stages in front of the ready decision in synchronized mode.
    localparam int RDY_SYNC_STAGES = 2;

    // True while the bus is being driven for an access.
    function automatic logic phase_busy(input xbw_phase_e ph);
        return ph != PH_IDLE;
    endfunction

    // True in the cycles where the write strobe is asserted.
    function automatic logic phase_strobe(input xbw_phase_e ph);
        return ph == PH_STROBE;
    endfunction

endpackage

// File: rtl/xbw_ready.sv
`timescale 1ns/1ps
module xbw_ready
    import xbw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ready_pin,
    input  logic sync_mode,
    output logic ready_dec
);
    logic [RDY_SYNC_STAGES-1:0] sync_q;
    logic [1:0]                 warm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[RDY_SYNC_STAGES-2:0], ready_pin};
        end
    end

    // Select which view of the pin the sequencer decides on.
    always_comb begin
        ready_dec = sync_mode ? sync_q[RDY_SYNC_STAGES-1] : ready_pin;
    end

    // Cycles since reset, used only to keep the delay check in a valid window.
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    // R5: synchronized view equals the pin two edges earlier
    a_r5_sync_delay: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (sync_q[RDY_SYNC_STAGES-1] == $past(ready_pin, 2)));

endmodule

// File: rtl/xbw_seq.sv
`timescale 1ns/1ps
module xbw_seq
    import xbw_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [CW-1:0] len_setup,
    input  logic [CW-1:0] len_strobe,
    input  logic [CW-1:0] len_hold,
    input  logic          rdy_en,
    input  logic          rdy_dec,
    output xbw_phase_e    phase,
    output logic          accept,
    output logic          done
);
    localparam int NW = CW + 2;

    logic [NW-1:0] n_setup, n_strobe, n_hold;
    logic [NW-1:0] end_strobe, end_all;
    logic [NW-1:0] cnt_q;
    logic          busy_q;
    logic          stall;

    // R10: zero length behaves as one cycle
    always_comb begin
        n_setup    = (len_setup  == '0) ? NW'(1) : NW'(len_setup);
        n_strobe   = (len_strobe == '0) ? NW'(1) : NW'(len_strobe);
        n_hold     = (len_hold   == '0) ? NW'(1) : NW'(len_hold);
        end_strobe = n_setup + n_strobe - NW'(1);
        end_all    = n_setup + n_strobe + n_hold - NW'(1);
    end

    always_comb begin
        accept = !busy_q && req_valid;
        stall  = busy_q && rdy_en && (cnt_q == end_strobe) && !rdy_dec;
        done   = busy_q && (cnt_q == end_all);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (done) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q && !stall) begin
            cnt_q  <= cnt_q + NW'(1);
        end
    end

    always_comb begin
        if (!busy_q) begin
            phase = PH_IDLE;
        end else if (cnt_q < n_setup) begin
            phase = PH_SETUP;
        end else if (cnt_q <= end_strobe) begin
            phase = PH_STROBE;
        end else begin
            phase = PH_HOLD;
        end
    end

    // R7: completion is a single-cycle pulse
    a_r7_ack_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2: an access only begins from a pending request
    a_r2_start_from_request: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(req_valid));

    // R4: a low decision at the end of the strobe stage keeps the strobe going
    a_r4_wait_extends: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE && cnt_q == end_strobe && rdy_en && !rdy_dec)
        |=> (phase == PH_STROBE));

endmodule

// File: rtl/xbw_pins.sv
`timescale 1ns/1ps
module xbw_pins
    import xbw_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  xbw_phase_e    phase,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          cs_n,
    output logic          we_n,
    output logic          rnw,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          wdata_oe
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    // Driver turns on one cycle after the strobe falls, off one cycle after the access ends.
    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= phase == PH_STROBE || phase == PH_HOLD;
        end
    end

    always_comb begin
        cs_n     = !phase_busy(phase);
        rnw      = !phase_busy(phase);
        we_n     = !phase_strobe(phase);
        addr     = addr_q;
        wdata    = data_q;
        wdata_oe = oe_q;
    end

    // R8: driver never turns on before the strobe has fallen
    a_r8_oe_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> $past(!we_n));

    // R9: address is frozen across idle cycles
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n)) |-> $stable(addr_q));

endmodule

// File: rtl/xbus_wr_ctrl.sv
`timescale 1ns/1ps
module xbus_wr_ctrl
    import xbw_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          req_ack,
    input  logic [CW-1:0] cfg_setup,
    input  logic [CW-1:0] cfg_strobe,
    input  logic [CW-1:0] cfg_hold,
    input  logic          cfg_rdy_en,
    input  logic          cfg_rdy_sync,
    input  logic          xb_ready,
    output logic          xb_cs_n,
    output logic          xb_we_n,
    output logic          xb_rnw,
    output logic [AW-1:0] xb_addr,
    output logic [DW-1:0] xb_wdata,
    output logic          xb_wdata_oe
);
    xbw_phase_e phase;
    logic       accept;
    logic       rdy_dec;

    xbw_ready u_ready (
        .clk       (clk),
        .rst       (rst),
        .ready_pin (xb_ready),
        .sync_mode (cfg_rdy_sync),
        .ready_dec (rdy_dec)
    );

    xbw_seq #(.CW(CW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .len_setup  (cfg_setup),
        .len_strobe (cfg_strobe),
        .len_hold   (cfg_hold),
        .rdy_en     (cfg_rdy_en),
        .rdy_dec    (rdy_dec),
        .phase      (phase),
        .accept     (accept),
        .done       (req_ack)
    );

    xbw_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .phase    (phase),
        .req_addr (req_addr),
        .req_data (req_data),
        .cs_n     (xb_cs_n),
        .we_n     (xb_we_n),
        .rnw      (xb_rnw),
        .addr     (xb_addr),
        .wdata    (xb_wdata),
        .wdata_oe (xb_wdata_oe)
    );

    // R3: strobe only inside chip-select
    a_r3_we_inside_cs: assert property (@(posedge clk) disable iff (rst)
        !xb_we_n |-> !xb_cs_n);

    // R3: chip-select rises only after the strobe has been high a full cycle
    a_r3_we_before_cs: assert property (@(posedge clk) disable iff (rst)
        $rose(xb_cs_n) |-> $past(xb_we_n));

    // R8: driver released only once read/not-write is back high
    a_r8_release_after_rnw: assert property (@(posedge clk) disable iff (rst)
        $fell(xb_wdata_oe) |-> ($past(xb_rnw) && xb_rnw));

endmodule

// File: tb/xbus_wr_ctrl_test.sv
`timescale 1ns/1ps
module xbus_wr_ctrl_test;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ack;
    logic [CW-1:0] cfg_setup = 4'd1;
    logic [CW-1:0] cfg_strobe = 4'd1;
    logic [CW-1:0] cfg_hold = 4'd1;
    logic          cfg_rdy_en = 1'b0;
    logic          cfg_rdy_sync = 1'b0;
    logic          xb_ready = 1'b0;
    logic          xb_cs_n, xb_we_n, xb_rnw, xb_wdata_oe;
    logic [AW-1:0] xb_addr;
    logic [DW-1:0] xb_wdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xbus_wr_ctrl #(.AW(AW), .DW(DW), .CW(CW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_ack(req_ack), .cfg_setup(cfg_setup),
        .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold), .cfg_rdy_en(cfg_rdy_en),
        .cfg_rdy_sync(cfg_rdy_sync), .xb_ready(xb_ready), .xb_cs_n(xb_cs_n),
        .xb_we_n(xb_we_n), .xb_rnw(xb_rnw), .xb_addr(xb_addr),
        .xb_wdata(xb_wdata), .xb_wdata_oe(xb_wdata_oe)
    );

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // One write access; rrise is the cycle index at which the ready pin goes high
    // (negative: high from before the access).
    task automatic run_write(input string wreq, input int ls, input int la, input int lt,
                             input bit sync_m, input bit en, input int rrise,
                             input logic [AW-1:0] a, input logic [DW-1:0] d);
        int sc, sa, st, first, waits, total;
        int cs_low, we_low, ack_idx, ack_cnt;
        int bad_rnw, bad_we, bad_oe, bad_data, bad_addr;
        sc = (ls == 0) ? 1 : ls;
        sa = (la == 0) ? 1 : la;
        st = (lt == 0) ? 1 : lt;
        first = sync_m ? sc + sa - 3 : sc + sa - 1;
        waits = (en && rrise > first) ? rrise - first : 0;
        total = sc + sa + st + waits;
        cs_low = 0; we_low = 0; ack_idx = -1; ack_cnt = 0;
        bad_rnw = 0; bad_we = 0; bad_oe = 0; bad_data = 0; bad_addr = 0;

        @(negedge clk);
        cfg_setup = ls[CW-1:0]; cfg_strobe = la[CW-1:0]; cfg_hold = lt[CW-1:0];
        cfg_rdy_sync = sync_m; cfg_rdy_en = en;
        xb_ready = (rrise < 0);
        req_addr = a; req_data = d; req_valid = 1'b1;
        @(posedge clk);
        for (int idx = 0; idx < total + 3; idx++) begin
            @(negedge clk);
            if (!xb_cs_n) cs_low++;
            if (!xb_we_n) we_low++;
            if (xb_rnw != (idx >= total)) bad_rnw++;
            if (xb_we_n != !(idx >= sc && idx < sc + sa + waits)) bad_we++;
            if (xb_wdata_oe != (idx >= sc + 1 && idx <= total)) bad_oe++;
            if (xb_wdata_oe && xb_wdata != d) bad_data++;
            if (xb_addr != a) bad_addr++;
            if (req_ack) begin
                ack_cnt++;
                ack_idx = idx;
                req_valid = 1'b0;
            end
            xb_ready = (idx >= rrise);
        end
        xb_ready = 1'b0;
        check("R2", "chip-select low cycles", cs_low, total);
        check("R2", "read/not-write mismatched cycles", bad_rnw, 0);
        check("R3", "write strobe mismatched cycles", bad_we, 0);
        check(wreq, "write strobe low cycles", we_low, sa + waits);
        check("R7", "acknowledge cycle index", ack_idx, total - 1);
        check("R7", "acknowledge pulse count", ack_cnt, 1);
        check("R8", "driver enable mismatched cycles", bad_oe, 0);
        check("R8", "driven data mismatched cycles", bad_data, 0);
        check("R9", "address mismatched cycles", bad_addr, 0);
    endtask

    // Idle cycles with changing host inputs and no request: nothing moves.
    task automatic idle_hold(input logic [AW-1:0] held);
        int cs_low, bad_addr, oe_high;
        cs_low = 0; bad_addr = 0; oe_high = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            req_addr = AW'(32'h5A5A5 + i);
            req_data = DW'(16'h1234 + i);
            if (!xb_cs_n) cs_low++;
            if (xb_addr != held) bad_addr++;
            if (xb_wdata_oe) oe_high++;
        end
        check("R2", "chip-select low while idle", cs_low, 0);
        check("R9", "address changed while idle", bad_addr, 0);
        check("R8", "driver enabled while idle", oe_high, 0);
    endtask

    task automatic reset_state();
        @(negedge clk);
        check("R1", "reset chip-select", xb_cs_n, 1);
        check("R1", "reset write strobe", xb_we_n, 1);
        check("R1", "reset read/not-write", xb_rnw, 1);
        check("R1", "reset driver enable", xb_wdata_oe, 0);
        check("R1", "reset acknowledge", req_ack, 0);
        check("R1", "reset address", xb_addr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        reset_state();
        rst = 1'b0;
        // R4: direct mode, ready already high, no waits
        run_write("R4", 2, 3, 2, 1'b0, 1'b1, -1, 20'h0A123, 16'hBEEF);
        // R4: direct mode, ready rises three cycles after the first sample
        run_write("R4", 1, 2, 1, 1'b0, 1'b1, 5, 20'h0B456, 16'h1357);
        // R5: synchronized mode, ready rises two cycles after the early sample
        run_write("R5", 1, 3, 2, 1'b1, 1'b1, 3, 20'h0C789, 16'h2468);
        // R5: synchronized mode, ready rises exactly at the early sample point
        run_write("R5", 2, 2, 1, 1'b1, 1'b1, 1, 20'h0D0D0, 16'hA5A5);
        // R6: ready disabled, pin held low throughout
        run_write("R6", 2, 2, 2, 1'b0, 1'b0, 1000, 20'h0E0E1, 16'h0F0F);
        // R10: zero lengths run as one cycle each
        run_write("R10", 0, 0, 0, 1'b0, 1'b1, -1, 20'h0F00F, 16'h7E7E);
        idle_hold(20'h0F00F);
        report();
        $finish;
    end
endmodule